// File: doc/BRIEF.md
# Scalable Feistel Round Datapath

This block is the combinational round of a lightweight, word-oriented Feistel cipher whose block width `N` and word width `B` are both parameters. Each half of the block is `N/2` bits wide and holds `NB = N/(2B)` words of `B` bits. Word 0 sits in the least significant bits of a half. Given the current left half, right half, a round key and a direction select, the block returns the next pair of halves in the same cycle. A surrounding sequencer holds the state registers, feeds back the outputs and supplies a fresh round key each cycle.

The mixing function applies four steps to the right half. First, each word is added to the matching key word modulo 2^B. Second, a 3-bit substitution is applied bit-slice by bit-slice across every group of three adjacent words. Third, a fixed bit-rotation pattern is applied over each word triplet. The result is XORed with the left half after that half has been word-rotated. Encryption rotates the words upward. Decryption rotates them downward. All rotations are pure wiring, so the only logic in the path is the adders and the substitution slices.

Top module: `feistel_round_dp`

## Requirements
- R1: `left_out` always equals `right_in`, in both directions.
- R2: With `encrypt` = 1, `right_out` = WordUp(`left_in`) XOR BitRot(Sub(`right_in` ⊞ `round_key`)).
- R3: With `encrypt` = 0, the same formula holds with WordDown in place of WordUp. WordDown moves word i+1 to position i, and word 0 wraps to position NB−1.
- R4: ⊞ adds each B-bit word modulo 2^B, and no carry passes into the next word. For example, all-ones words plus a key of 1 in every word give all-zero words.
- R5: Sub maps 0→0, 1→5, 2→6, 3→7, 4→4, 5→3, 6→1, 7→2. For triplet t and bit j, the 3-bit input is formed with bit j of word 3t as the LSB, bit j of word 3t+1 as the middle bit and bit j of word 3t+2 as the MSB. Each output bit returns to the position its input bit came from.
- R6: BitRot rotates word 3t right by one bit (bit j takes bit j+1 mod B). It leaves word 3t+1 unchanged. It rotates word 3t+2 left by one bit (bit j takes bit j−1 mod B).
- R7: WordUp moves word i to position i+1 for i < NB−1, and the top word wraps to position 0.
- R8: The same rules hold for every legal geometry (N a multiple of 6B), including B = 1, where the bit rotations degenerate to identity. An illegal geometry is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| left_in | input | N/2 | Current left half |
| right_in | input | N/2 | Current right half |
| round_key | input | N/2 | Round key for this round |
| encrypt | input | 1 | 1 selects upward word rotation, 0 selects downward |
| left_out | output | N/2 | Next left half |
| right_out | output | N/2 | Next right half |

## Verification
The word rotation of the left half and the substitution path of the right half meet in the final XOR, so two effects land in the same output word in the same evaluation. This is provoked in two ways. Directed vectors place a single marked word in the left half while the right half and key are chosen so that the substitution outputs either zero or a known bit pattern. Random vectors exercise both paths at once, in both directions, on five geometries. Every `right_out` is judged bit-exact against a bench model that computes each step from the requirements, using its own table encoding and index arithmetic.

// File: rtl/feistel_round_pkg.sv
package feistel_round_pkg;

   // 3-bit substitution used in the bit-sliced layer
   function automatic logic [2:0] sub3(input logic [2:0] x);
      logic [2:0] y;
      case (x)
         3'd0: y = 3'd0;
         3'd1: y = 3'd5;
         3'd2: y = 3'd6;
         3'd3: y = 3'd7;
         3'd4: y = 3'd4;
         3'd5: y = 3'd3;
         3'd6: y = 3'd1;
         default: y = 3'd2;
      endcase
      return y;
   endfunction

   function automatic bit geometry_ok(input int n, input int b);
      return (b > 0) && (n > 0) && ((n % (6 * b)) == 0);
   endfunction

endpackage

// File: rtl/feistel_word_add.sv
module feistel_word_add #(
   parameter int B  = 4,
   parameter int NB = 6,
   localparam int H = B * NB
) (
   input  logic [H-1:0] a,
   input  logic [H-1:0] k,
   output logic [H-1:0] sum
);
   for (genvar w = 0; w < NB; w++) begin : g_word
      assign sum[w*B +: B] = a[w*B +: B] + k[w*B +: B];
   end

   always_comb begin
      if (!$isunknown({a, k}) && (k == '0))
         AST_ADD_ZERO_KEY: assert (sum == a) else $error("zero key altered words"); // R4
   end
endmodule

// File: rtl/feistel_sbox_layer.sv
module feistel_sbox_layer #(
   parameter int B  = 4,
   parameter int NB = 6,
   localparam int H  = B * NB,
   localparam int NT = NB / 3
) (
   input  logic [H-1:0] x,
   output logic [H-1:0] y
);
   import feistel_round_pkg::*;

   for (genvar t = 0; t < NT; t++) begin : g_trip
      for (genvar j = 0; j < B; j++) begin : g_bit
         logic [2:0] s_in, s_out;
         assign s_in = {x[(3*t+2)*B + j], x[(3*t+1)*B + j], x[(3*t)*B + j]};
         assign s_out = sub3(s_in);
         assign y[(3*t)*B + j]   = s_out[0];
         assign y[(3*t+1)*B + j] = s_out[1];
         assign y[(3*t+2)*B + j] = s_out[2];
      end
   end

   always_comb begin
      if (!$isunknown(x) && (x == '0))
         AST_SUB_ZERO_FIXED: assert (y == '0) else $error("zero not a fixed point"); // R5
   end
endmodule

// File: rtl/feistel_bit_rot.sv
module feistel_bit_rot #(
   parameter int B  = 4,
   parameter int NB = 6,
   localparam int H  = B * NB,
   localparam int NT = NB / 3
) (
   input  logic [H-1:0] x,
   output logic [H-1:0] y
);
   for (genvar t = 0; t < NT; t++) begin : g_trip
      localparam int W0 = (3*t)   * B;
      localparam int W1 = (3*t+1) * B;
      localparam int W2 = (3*t+2) * B;
      if (B == 1) begin : g_identity
         assign y[W0 +: 3] = x[W0 +: 3];
      end else begin : g_rotate
         assign y[W0 +: B] = {x[W0], x[W0+B-1 : W0+1]};
         assign y[W1 +: B] = x[W1 +: B];
         assign y[W2 +: B] = {x[W2+B-2 : W2], x[W2+B-1]};
      end
   end

   always_comb begin
      if (!$isunknown(x))
         AST_BITROT_WEIGHT: assert ($countones(y) == $countones(x)) else $error("bit rotation lost bits"); // R6
   end
endmodule

// File: rtl/feistel_word_rot.sv
module feistel_word_rot #(
   parameter int B  = 4,
   parameter int NB = 6,
   localparam int H = B * NB
) (
   input  logic [H-1:0] x,
   input  logic         upward,
   output logic [H-1:0] y
);
   logic [H-1:0] up_w, down_w;

   for (genvar i = 0; i < NB; i++) begin : g_word
      localparam int NXT = (i + 1) % NB;
      assign up_w[NXT*B +: B] = x[i*B +: B];
      assign down_w[i*B +: B] = x[NXT*B +: B];
   end

   assign y = upward ? up_w : down_w;

   always_comb begin
      if (!$isunknown({x, upward})) begin
         AST_WROT_WEIGHT: assert ($countones(y) == $countones(x)) else $error("word rotation lost bits"); // R7
         AST_WROT_TOP_WRAP: assert (!upward || (y[B-1:0] == x[H-1 -: B])) else $error("top word did not wrap"); // R7
      end
   end
endmodule

// File: rtl/feistel_round_dp.sv
module feistel_round_dp #(
   parameter int N = 48,
   parameter int B = 4,
   localparam int H  = N / 2,
   localparam int NB = H / B
) (
   input  logic [H-1:0] left_in,
   input  logic [H-1:0] right_in,
   input  logic [H-1:0] round_key,
   input  logic         encrypt,
   output logic [H-1:0] left_out,
   output logic [H-1:0] right_out
);
   import feistel_round_pkg::*;

   if (!geometry_ok(N, B)) begin : g_bad_geometry
      $error("N must be a positive multiple of 6*B");
   end

   logic [H-1:0] added, subbed, mixed, rotated;

   feistel_word_add   #(.B(B), .NB(NB)) u_add (.a(right_in), .k(round_key), .sum(added));
   feistel_sbox_layer #(.B(B), .NB(NB)) u_sub (.x(added), .y(subbed));
   feistel_bit_rot    #(.B(B), .NB(NB)) u_brot (.x(subbed), .y(mixed));
   feistel_word_rot   #(.B(B), .NB(NB)) u_wrot (.x(left_in), .upward(encrypt), .y(rotated));

   assign left_out  = right_in;
   assign right_out = rotated ^ mixed;

   always_comb begin
      if (!$isunknown({left_in, right_in, round_key}) && (left_in == '0))
         AST_ZERO_LEFT_MIX: assert (right_out == mixed) else $error("left path leaked"); // R2
   end
endmodule

// File: tb/feistel_round_dp_lane.sv
module feistel_round_dp_lane #(
   parameter int N = 48,
   parameter int B = 4,
   parameter int SEED = 1,
   localparam int H  = N / 2,
   localparam int NB = H / B
) (
   input  logic clk,
   input  logic go,
   output logic done,
   output int   checks,
   output int   errors
);
   // entry v occupies bits [3v+2:3v]
   localparam logic [23:0] SUB_TAB = {3'd2, 3'd1, 3'd3, 3'd4, 3'd7, 3'd6, 3'd5, 3'd0};

   logic [H-1:0] l_i, r_i, k_i, l_o, r_o;
   logic         enc;

   feistel_round_dp #(.N(N), .B(B)) uut (
      .left_in(l_i), .right_in(r_i), .round_key(k_i), .encrypt(enc),
      .left_out(l_o), .right_out(r_o));

   function automatic logic [H-1:0] model_right(logic [H-1:0] l, logic [H-1:0] r,
                                                logic [H-1:0] k, logic up);
      logic [H-1:0] s, sb, br, wr;
      for (int w = 0; w < NB; w++) s[w*B +: B] = r[w*B +: B] + k[w*B +: B];
      sb = s;
      for (int t = 0; t < NB/3; t++)
         for (int j = 0; j < B; j++) begin
            int idx;
            idx = s[3*t*B + j] + 2*s[(3*t+1)*B + j] + 4*s[(3*t+2)*B + j];
            sb[3*t*B + j]     = SUB_TAB[3*idx];
            sb[(3*t+1)*B + j] = SUB_TAB[3*idx + 1];
            sb[(3*t+2)*B + j] = SUB_TAB[3*idx + 2];
         end
      br = sb;
      for (int t = 0; t < NB/3; t++)
         for (int j = 0; j < B; j++) begin
            br[3*t*B + j]     = sb[3*t*B + ((j + 1) % B)];
            br[(3*t+2)*B + j] = sb[(3*t+2)*B + ((j + B - 1) % B)];
         end
      for (int i = 0; i < NB; i++) begin
         if (up) wr[((i + 1) % NB)*B +: B] = l[i*B +: B];
         else    wr[i*B +: B] = l[((i + 1) % NB)*B +: B];
      end
      return wr ^ br;
   endfunction

   function automatic logic [H-1:0] rnd_half();
      logic [127:0] v;
      v = {$urandom, $urandom, $urandom, $urandom};
      return v[H-1:0];
   endfunction

   function automatic logic [H-1:0] each_word(int val);
      logic [H-1:0] v;
      for (int w = 0; w < NB; w++) v[w*B +: B] = val[B-1:0];
      return v;
   endfunction

   task automatic check(string tag, logic [H-1:0] got, logic [H-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s N=%0d B=%0d got %h expected %h", tag, N, B, got, exp);
      end
   endtask

   task automatic apply(string tag, logic [H-1:0] l, logic [H-1:0] r,
                        logic [H-1:0] k, logic up);
      @(posedge clk);
      l_i = l; r_i = r; k_i = k; enc = up;
      @(negedge clk);
      check("R1", l_o, r);
      check(tag, r_o, model_right(l, r, k, up));
   endtask

   initial begin
      logic [H-1:0] one_bit, word0;
      done = 0; checks = 0; errors = 0;
      l_i = '0; r_i = '0; k_i = '0; enc = 1'b1;
      void'($urandom(SEED));
      wait (go);
      // all-zero inputs give all-zero outputs
      @(negedge clk);
      check("R2", r_o, '0);
      check("R1", l_o, '0);
      // R4: all-ones plus one per word wraps to zero inside each word
      apply("R4", '0, each_word(-1), each_word(1), 1'b1);
      check("R4", r_o, '0);
      // R7 / R3: single marked word in the left half, sub path silent
      word0 = '0; word0[B-1:0] = 1;
      apply("R7", word0, '0, '0, 1'b1);
      check("R7", r_o, word0 << (B % H));
      apply("R3", word0, '0, '0, 1'b0);
      check("R3", r_o, word0 << (H - B));
      // R5 / R6: one input bit set in word 0
      one_bit = '0; one_bit[0] = 1'b1;
      apply("R5", '0, one_bit, '0, 1'b1);
      apply("R6", '0, each_word(1), '0, 1'b1);
      // R5: all-ones triplet input maps to 2 in every slice
      apply("R5", '0, '1, '0, 1'b0);
      // random mix of both paths, both directions
      for (int n = 0; n < 80; n++)
         apply(n[0] ? "R2" : "R3", rnd_half(), rnd_half(), rnd_half(), n[0]);
      for (int n = 0; n < 20; n++)
         apply("R8", rnd_half(), rnd_half(), '1, n[1]);
      done = 1;
   end
endmodule

// File: tb/feistel_round_dp_test.sv
module feistel_round_dp_test;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 5;

   logic clk = 0;
   logic go = 0;
   logic [LANES-1:0] done;
   int ch[LANES];
   int er[LANES];

   always #(CLK_PERIOD/2) clk = ~clk;

   // R8: several legal geometries, including the B = 1 identity variant
   feistel_round_dp_lane #(.N(48), .B(4), .SEED(11)) uut      (.clk(clk), .go(go), .done(done[0]), .checks(ch[0]), .errors(er[0]));
   feistel_round_dp_lane #(.N(48), .B(8), .SEED(23)) lane_b8  (.clk(clk), .go(go), .done(done[1]), .checks(ch[1]), .errors(er[1]));
   feistel_round_dp_lane #(.N(72), .B(6), .SEED(37)) lane_b6  (.clk(clk), .go(go), .done(done[2]), .checks(ch[2]), .errors(er[2]));
   feistel_round_dp_lane #(.N(96), .B(8), .SEED(41)) lane_96  (.clk(clk), .go(go), .done(done[3]), .checks(ch[3]), .errors(er[3]));
   feistel_round_dp_lane #(.N(6),  .B(1), .SEED(53)) lane_b1  (.clk(clk), .go(go), .done(done[4]), .checks(ch[4]), .errors(er[4]));

   initial begin
      int total_c, total_e, cyc;
      bit timed_out;
      timed_out = 0;
      cyc = 0;
      repeat (3) @(posedge clk);
      go = 1;
      while (done != '1 && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (done != '1) timed_out = 1;
      @(negedge clk);
      total_c = 0; total_e = 0;
      for (int i = 0; i < LANES; i++) begin
         total_c += ch[i];
         total_e += er[i];
      end
      if (timed_out) begin
         total_c++;
         total_e++;
         $display("FAIL watchdog: lanes done %b expected %b", done, {LANES{1'b1}});
      end
      $display("  CHECKS %0d ERRORS %0d", total_c, total_e);
      $finish;
   end
endmodule